// File: doc/BRIEF.md
# Tap-Selectable Delay Line

This block is a serial-in, serial-out delay line of up to sixteen stages. Each enabled rising clock edge moves the word at the input into the first stage and moves every stage one place along. A tap address picks which stage reaches the main output. The path from that stage to the output is combinational, so the delay can be changed on any cycle without a clock edge. The length in enabled cycles is the tap value plus one: a tap of binary 0010 gives a delay of three.

A second output always shows the deepest stage, whatever the tap is. Instances can therefore be chained into longer delays. One example is rebalancing two pipeline paths: a path that arrives nine cycles early gets a tap of 8. A build parameter can put one more register on the main output. That adds one enabled cycle of delay, and the synchronous reset clears it. The stages themselves have no reset. A user must push a full line of known words through before relying on the outputs.

Top module: `dyn_shift_delay`

## Requirements
- R1: On a rising edge with `ce` high, stage 0 takes `din` and each stage k (k >= 1) takes the old value of stage k-1. With `tap` = 0 the main output shows the most recent enabled input.
- R2: With OUT_REG = 0, `q` equals the `din` value captured tap+1 enabled edges earlier. For example, `tap` = 4'b0010 gives a delay of three.
- R3: On a rising edge with `ce` low, no stage changes, so `q_last` and the combinational `q` keep their values.
- R4: A change of `tap` changes `q` within the same cycle, before any clock edge.
- R5: `q_last` always equals the `din` value captured sixteen enabled edges earlier, whatever `tap` is.
- R6: When `q_last` of one instance feeds `din` of a second instance that shares the same `ce`, the second instance's `q` equals the input captured 16+tap+1 enabled edges earlier.
- R7: With OUT_REG = 1, a rising edge with `rst` high sets `q` to zero. Reset leaves the stage contents and `q_last` untouched.
- R8: With OUT_REG = 1, an enabled edge loads `q` with the stage that `tap` selects before the edge, which gives a delay of tap+2. A disabled edge leaves `q` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the optional output register |
| ce | input | 1 | Shift enable |
| din | input | DATA_W | Serial data word in |
| tap | input | ADDR_W | Stage select; delay is tap+1 (tap+2 with OUT_REG) |
| q | output | DATA_W | Selected stage, optionally registered |
| q_last | output | DATA_W | Deepest stage, for chaining |

## Verification
The assertions check on every cycle that an enabled edge moves every stage one place along, and that a disabled edge freezes the deepest stage. They also check that the combinational output holds while both the tap and the line are still, and that the output register clears on reset and holds when disabled. Some behaviour only the bench scenarios can show. This covers the end-to-end delay for each tap value, a tap change taking effect inside a cycle, and reset leaving the stages untouched. It also covers the delay of 16+tap+1 through two chained instances, because all of these depend on the history of the input words.

// File: rtl/dasr_pkg.sv
package dasr_pkg;
  // Width of a stage index, at least one bit.
  function automatic int unsigned idx_width(input int unsigned depth);
    return (depth <= 2) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/dasr_stage_chain.sv
module dasr_stage_chain #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16
) (
  input  logic                    clk,
  input  logic                    ce,
  input  logic [DATA_W-1:0]       din,
  output logic [DEPTH*DATA_W-1:0] stage_flat
);
  logic [DATA_W-1:0] stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (ce) stg[0] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (ce) stg[i] <= stg[i-1];
      end
    end
    assign stage_flat[i*DATA_W +: DATA_W] = stg[i];
  end
endmodule

// File: rtl/dasr_tap_mux.sv
module dasr_tap_mux #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic [DEPTH*DATA_W-1:0] stage_flat,
  input  logic [ADDR_W-1:0]       tap,
  output logic [DATA_W-1:0]       sel
);
  // Out-of-range taps fall back to the deepest stage.
  always_comb begin
    sel = stage_flat[(DEPTH-1)*DATA_W +: DATA_W];
    for (int k = 0; k < DEPTH; k++) begin
      if (int'(tap) == k) sel = stage_flat[k*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/dasr_out_stage.sv
module dasr_out_stage #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ce) q <= d;
  end
endmodule

// File: rtl/dyn_shift_delay.sv
module dyn_shift_delay #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DEPTH   = 16,
  parameter bit          OUT_REG = 1'b0,
  localparam int unsigned ADDR_W = dasr_pkg::idx_width(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [DATA_W-1:0] din,
  input  logic [ADDR_W-1:0] tap,
  output logic [DATA_W-1:0] q,
  output logic [DATA_W-1:0] q_last
);
  logic [DEPTH*DATA_W-1:0] stage_flat;
  logic [DATA_W-1:0]       tap_word;

  dasr_stage_chain #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chain (
    .clk(clk), .ce(ce), .din(din), .stage_flat(stage_flat)
  );

  dasr_tap_mux #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mux (
    .stage_flat(stage_flat), .tap(tap), .sel(tap_word)
  );

  assign q_last = stage_flat[(DEPTH-1)*DATA_W +: DATA_W];

  if (OUT_REG) begin : g_reg_out
    dasr_out_stage #(.DATA_W(DATA_W)) u_out (
      .clk(clk), .rst(rst), .ce(ce), .d(tap_word), .q(q)
    );
  end else begin : g_comb_out
    logic rst_unused;
    assign rst_unused = rst;
    assign q = tap_word;
  end
endmodule

// File: rtl/dyn_shift_delay_chk.sv
module dyn_shift_delay_chk #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DEPTH   = 16,
  parameter bit          OUT_REG = 1'b0,
  parameter int unsigned ADDR_W  = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    ce,
  input logic [ADDR_W-1:0]       tap,
  input logic [DATA_W-1:0]       q,
  input logic [DATA_W-1:0]       q_last,
  input logic [DEPTH*DATA_W-1:0] stage_flat
);
  // R1
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    ce |=> (stage_flat[DEPTH*DATA_W-1:DATA_W] == $past(stage_flat[(DEPTH-1)*DATA_W-1:0])));

  // R3
  hold_line_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(q_last));

  if (OUT_REG) begin : g_reg_chk
    // R7
    reg_clear_chk: assert property (@(posedge clk)
      rst |=> (q == '0));
    // R8
    reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !ce |=> $stable(q));
  end else begin : g_comb_chk
    // R4
    tap_still_chk: assert property (@(posedge clk) disable iff (rst)
      !ce |=> (!$stable(tap) || $stable(q)));
  end
endmodule

bind dyn_shift_delay dyn_shift_delay_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .OUT_REG(OUT_REG), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst(rst), .ce(ce), .tap(tap), .q(q), .q_last(q_last),
  .stage_flat(stage_flat)
);

// File: tb/dyn_shift_delay_test.sv
module dyn_shift_delay_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst, ce;
  logic [W-1:0] din;
  logic [3:0] tap, tap2;
  logic [W-1:0] q, q_last, qr, qr_last, q2, q2_last;

  int checks = 0;
  int failures = 0;
  bit checking = 0;
  bit done = 0;

  logic [W-1:0] hist [48];
  logic [W-1:0] qr_model;

  always #(CLK_PERIOD/2) clk = ~clk;

  dyn_shift_delay #(.DATA_W(W), .DEPTH(16), .OUT_REG(1'b0)) uut (
    .clk(clk), .rst(rst), .ce(ce), .din(din), .tap(tap), .q(q), .q_last(q_last));
  dyn_shift_delay #(.DATA_W(W), .DEPTH(16), .OUT_REG(1'b1)) uut_reg (
    .clk(clk), .rst(rst), .ce(ce), .din(din), .tap(tap), .q(qr), .q_last(qr_last));
  dyn_shift_delay #(.DATA_W(W), .DEPTH(16), .OUT_REG(1'b0)) uut_tail (
    .clk(clk), .rst(rst), .ce(ce), .din(q_last), .tap(tap2), .q(q2), .q_last(q2_last));

  task automatic chk(input logic [W-1:0] got, input logic [W-1:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic cyc(input bit rst_v, input bit ce_v, input logic [W-1:0] d,
                     input logic [3:0] t, input logic [3:0] t2);
    @(negedge clk);
    rst = rst_v; ce = ce_v; din = d; tap = t; tap2 = t2;
    #1;
    if (checking) begin
      // R4: new tap already visible before the edge
      chk(q, hist[t], (t == 0) ? "R1" : (ce_v ? "R2" : "R4"));
      chk(q_last, hist[15], "R5");
      chk(qr_last, hist[15], "R7");
      chk(q2, hist[16 + t2], "R6");
      chk(qr, qr_model, "R8");
    end
    @(posedge clk);
    #1;
    if (rst_v) qr_model = '0;
    else if (ce_v) qr_model = hist[t];
    if (ce_v) begin
      for (int k = 47; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = d;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 48; k++) hist[k] = '0;
    qr_model = '0;
    rst = 1'b1; ce = 1'b0; din = '0; tap = '0; tap2 = '0;
    cyc(1, 0, 8'h00, 4'd0, 4'd0);
    cyc(1, 0, 8'h00, 4'd0, 4'd0);
    #1;
    chk(qr, 8'h00, "R7");
    // flush: two full lines of known words through both chained instances
    for (int i = 0; i < 40; i++) cyc(0, 1, W'(i * 29 + 3), 4'(i), 4'(i));
    checking = 1;
    // tap sweep, continuous enable
    for (int t = 0; t < 16; t++)
      for (int j = 0; j < 3; j++) cyc(0, 1, W'(t * 37 + j * 11 + 5), 4'(t), 4'(15 - t));
    // tap 2 gives delay 3 (R2)
    for (int j = 0; j < 4; j++) cyc(0, 1, W'(j + 8'hA0), 4'b0010, 4'd2);
    // gapped enable with tap changing every cycle (R3, R4, R8)
    for (int i = 0; i < 60; i++)
      cyc(0, (i % 3) != 0, W'(i * 53 + 17), 4'((i * 7) % 16), 4'((i * 5) % 16));
    // long hold
    for (int i = 0; i < 6; i++) cyc(0, 0, W'(8'hEE), 4'(i * 3), 4'(i));
    // mid-run reset: only the output register clears (R7)
    cyc(1, 1, 8'h5A, 4'd9, 4'd1);
    for (int i = 0; i < 20; i++) cyc(0, (i % 4) != 1, W'(i * 19 + 2), 4'(15 - i % 16), 4'(i % 16));
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule